// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank

A single bank of general-purpose pins behind a word-wide register port. Software drives pin outputs and output enables only through write-one aliases: a one in a set alias raises the matching bit, a one in a clear alias lowers it, and zero bits leave it alone. The current pad levels are readable after a two-flop synchronizer. This keeps a read-modify-write cycle out of the driver path.

Each pin has its own rising-edge enable and its own falling-edge enable. A detected edge on an enabled pin sets a pending bit. Pending bits are cleared by writing ones to the pending register. One interrupt line is the OR of every pending bit. Only edges produce interrupts; there is no level mode.

The register port decodes each access into a named register selection: input level, output-enable, pending, output-set, output-clear, enable-set, enable-clear, rise-enable, fall-enable, or none. Writes complete on the clock edge. Reads return data combinationally from the address.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register is zero. `pad_out`, `pad_oe` and `irq` are low, and the output-enable (0x04) and pending (0x0C) registers read zero.
- R2: Writing a mask to 0x14 sets those bits of `pad_out`. Writing a mask to 0x18 clears them. Zero bits in either write leave `pad_out` unchanged.
- R3: Writing a mask to 0x1C sets those bits of the output-enable register, and writing to 0x20 clears them. The register reads back at 0x04 and drives `pad_oe` (1 = driven, 0 = input).
- R4: A read of 0x00 returns `pad_in` delayed by two clock edges through a synchronizer. A change is not yet visible one edge after it is applied.
- R5: 0x28 (rise enable) and 0x2C (fall enable) are read/write registers. A synchronized 0→1 on a pin with its rise bit set sets its pending bit. A 1→0 on a pin with its fall bit set does the same. With both bits set, either edge is caught. The pending bit is set on the third clock edge after the pad change.
- R6: Writing ones to 0x0C clears those pending bits, and zero bits leave them alone. Pending bits are otherwise held.
- R7: When an enabled edge and a clear of the same pending bit occur on the same clock edge, the bit stays set.
- R8: `irq` is high exactly while any pending bit is set. Clearing an edge enable does not clear a bit that is already pending.
- R9: An edge on a pin whose matching edge enable is clear sets no pending bit and does not raise `irq`.
- R10: A write to 0x00 or to an unmapped address changes no register or output. The write-only aliases (0x14, 0x18, 0x1C, 0x20) and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one access per asserted cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output data to pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt, OR of pending bits |

## Verification
Bad output or enable state shows at `pad_out` or `pad_oe` on the first negative edge after the write. The enable state can also be read back at once. A wrong synchronizer depth appears as an input read or a pending bit one edge early or late. The bench samples exactly two and three edges after each pad change to catch this. A lost pending bit or a wrongly ordered set/clear shows at `irq` and at the pending register on the cycle after the colliding write. An enable that leaks shows as a pending bit where none is expected, three edges after an edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register selection produced by the address decoder.
    typedef enum logic [3:0] {
        RS_NONE,
        RS_LEVEL,
        RS_OE,
        RS_PEND,
        RS_OSET,
        RS_OCLR,
        RS_OESET,
        RS_OECLR,
        RS_RISE,
        RS_FALL
    } reg_sel_e;

    // Byte offsets; software depends on these values.
    localparam logic [7:0] OFS_LEVEL = 8'h00;
    localparam logic [7:0] OFS_OE    = 8'h04;
    localparam logic [7:0] OFS_PEND  = 8'h0C;
    localparam logic [7:0] OFS_OSET  = 8'h14;
    localparam logic [7:0] OFS_OCLR  = 8'h18;
    localparam logic [7:0] OFS_OESET = 8'h1C;
    localparam logic [7:0] OFS_OECLR = 8'h20;
    localparam logic [7:0] OFS_RISE  = 8'h28;
    localparam logic [7:0] OFS_FALL  = 8'h2C;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_bank_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);

    always_comb begin
        unique case (addr)
            AW'(OFS_LEVEL): sel = RS_LEVEL;
            AW'(OFS_OE):    sel = RS_OE;
            AW'(OFS_PEND):  sel = RS_PEND;
            AW'(OFS_OSET):  sel = RS_OSET;
            AW'(OFS_OCLR):  sel = RS_OCLR;
            AW'(OFS_OESET): sel = RS_OESET;
            AW'(OFS_OECLR): sel = RS_OECLR;
            AW'(OFS_RISE):  sel = RS_RISE;
            AW'(OFS_FALL):  sel = RS_FALL;
            default:        sel = RS_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;
    assign rise  = sync_q & ~prev_q;
    assign fall  = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_pending.sv
module gpio_pending #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt,
    input  logic         clr_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] pend
);

    logic [W-1:0] pend_q;
    logic [W-1:0] clr_w;

    assign clr_w = clr_en ? clr_mask : '0;

    // A new event is ORed after the clear, so it survives a same-cycle clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_w) | evt;
        end
    end

    assign pend = pend_q;

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic             irq
);

    reg_sel_e         sel;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] oe_q;
    logic [NPINS-1:0] ren_q;
    logic [NPINS-1:0] fen_q;
    logic [NPINS-1:0] level_w;
    logic [NPINS-1:0] rise_w;
    logic [NPINS-1:0] fall_w;
    logic [NPINS-1:0] evt_w;
    logic [NPINS-1:0] pend_w;
    logic             pend_clr;

    gpio_reg_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .level  (level_w),
        .rise   (rise_w),
        .fall   (fall_w)
    );

    assign evt_w    = (rise_w & ren_q) | (fall_w & fen_q);
    assign pend_clr = bus_wr && (sel == RS_PEND);

    gpio_pending #(.W(NPINS)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_w),
        .clr_en   (pend_clr),
        .clr_mask (bus_wdata),
        .pend     (pend_w)
    );

    // Register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            oe_q  <= '0;
            ren_q <= '0;
            fen_q <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                RS_OSET:  out_q <= out_q | bus_wdata;
                RS_OCLR:  out_q <= out_q & ~bus_wdata;
                RS_OESET: oe_q  <= oe_q | bus_wdata;
                RS_OECLR: oe_q  <= oe_q & ~bus_wdata;
                RS_RISE:  ren_q <= bus_wdata;
                RS_FALL:  fen_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Read data and outputs
    always_comb begin
        unique case (sel)
            RS_LEVEL: bus_rdata = level_w;
            RS_OE:    bus_rdata = oe_q;
            RS_PEND:  bus_rdata = pend_w;
            RS_RISE:  bus_rdata = ren_q;
            RS_FALL:  bus_rdata = fen_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = out_q;
    assign pad_oe  = oe_q;
    assign irq     = |pend_w;

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic             irq,
    input logic [NPINS-1:0] pend,
    input logic [NPINS-1:0] evt,
    input logic [NPINS-1:0] edge_en
);

    logic wr_out;
    logic wr_oe;
    logic wr_pend;

    assign wr_out  = bus_wr && (bus_addr == AW'(OFS_OSET) || bus_addr == AW'(OFS_OCLR));
    assign wr_oe   = bus_wr && (bus_addr == AW'(OFS_OESET) || bus_addr == AW'(OFS_OECLR));
    assign wr_pend = bus_wr && (bus_addr == AW'(OFS_PEND));

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_out == '0 && pad_oe == '0 && !irq)); // R1

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !wr_out |=> $stable(pad_out)); // R2

    AST_OE_HELD: assert property (@(posedge clk) disable iff (rst)
        !wr_oe |=> $stable(pad_oe)); // R3

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
        !wr_pend |=> ((pend & $past(pend)) == $past(pend))); // R6

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((pend & $past(evt)) == $past(evt))); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(edge_en) != '0)); // R9

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .irq      (irq),
    .pend     (pend_w),
    .evt      (evt_w),
    .edge_en  (ren_q | fen_q)
);

// File: tb/gpio_edge_bank_test.sv
`timescale 1ns/1ps
module gpio_edge_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_bank uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'hFC;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 8'hFC;
    endtask

    // Change the pads at a negative edge, then wait until the pending bit would be set.
    task automatic set_pads(input logic [31:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        bus_read(8'h04, r); check("R1 oe read", r, 32'h0);
        bus_read(8'h0C, r); check("R1 pend read", r, 32'h0);
    endtask

    task automatic t_outputs();
        bus_write(8'h14, 32'hF0F0_00A5);
        check("R2 set", pad_out, 32'hF0F0_00A5);
        bus_write(8'h18, 32'h0000_0005);
        check("R2 clear", pad_out, 32'hF0F0_00A0);
        bus_write(8'h14, 32'h0);
        check("R2 zero mask", pad_out, 32'hF0F0_00A0);
    endtask

    task automatic t_oe();
        logic [31:0] r;
        bus_write(8'h1C, 32'h0000_FFFF);
        check("R3 pad_oe set", pad_oe, 32'h0000_FFFF);
        bus_write(8'h20, 32'h0000_00FF);
        bus_read(8'h04, r); check("R3 oe readback", r, 32'h0000_FF00);
        check("R3 pad_oe clear", pad_oe, 32'h0000_FF00);
    endtask

    task automatic t_input();
        logic [31:0] r;
        @(negedge clk);
        pad_in = 32'h1234_5678;
        @(negedge clk);
        #1 bus_addr = 8'h00;
        #1 check("R4 not yet visible", bus_rdata, 32'h0);
        @(negedge clk);
        #1 check("R4 visible after two edges", bus_rdata, 32'h1234_5678);
        bus_read(8'h00, r); check("R4 level", r, 32'h1234_5678);
        set_pads(32'h0);
    endtask

    task automatic t_no_enable();
        logic [31:0] r;
        set_pads(32'h0000_0008);
        bus_read(8'h0C, r); check("R9 no pending", r, 32'h0);
        check("R9 irq low", {31'h0, irq}, 32'h0);
        set_pads(32'h0);
    endtask

    task automatic t_rise_fall();
        logic [31:0] r;
        bus_write(8'h28, 32'h0000_0001);
        set_pads(32'h0000_0001);
        bus_read(8'h0C, r); check("R5 rising pending", r, 32'h1);
        check("R8 irq high", {31'h0, irq}, 32'h1);
        set_pads(32'h0);
        bus_read(8'h0C, r); check("R5 fall ignored on rise-only pin", r, 32'h1);
        bus_write(8'h0C, 32'h0);
        bus_read(8'h0C, r); check("R6 zero mask keeps", r, 32'h1);
        bus_write(8'h0C, 32'h1);
        bus_read(8'h0C, r); check("R6 w1c", r, 32'h0);
        check("R8 irq low", {31'h0, irq}, 32'h0);
        bus_write(8'h2C, 32'h0000_0002);
        set_pads(32'h0000_0002);
        bus_read(8'h0C, r); check("R5 rise ignored on fall-only pin", r, 32'h0);
        set_pads(32'h0);
        bus_read(8'h0C, r); check("R5 falling pending", r, 32'h2);
        bus_write(8'h0C, 32'h2);
        bus_write(8'h28, 32'h0000_0011);
        bus_write(8'h2C, 32'h0000_0012);
        bus_read(8'h28, r); check("R5 rise readback", r, 32'h11);
        bus_read(8'h2C, r); check("R5 fall readback", r, 32'h12);
        set_pads(32'h0000_0010);
        bus_read(8'h0C, r); check("R5 both: rise", r, 32'h10);
        bus_write(8'h0C, 32'h10);
        set_pads(32'h0);
        bus_read(8'h0C, r); check("R5 both: fall", r, 32'h10);
        bus_write(8'h0C, 32'hFFFF_FFFF);
    endtask

    task automatic t_collision();
        logic [31:0] r;
        set_pads(32'h0000_0011);
        bus_read(8'h0C, r); check("R7 setup", r, 32'h11);
        // Fall on pin 4 is evaluated on the same edge as the clear write.
        @(negedge clk);
        pad_in = 32'h0000_0001;
        @(negedge clk);
        bus_write(8'h0C, 32'h11);
        bus_read(8'h0C, r); check("R7 edge wins over clear", r, 32'h10);
    endtask

    task automatic t_disable_keeps();
        logic [31:0] r;
        bus_write(8'h28, 32'h0);
        bus_write(8'h2C, 32'h0);
        bus_read(8'h0C, r); check("R8 pending kept after disable", r, 32'h10);
        check("R8 irq still high", {31'h0, irq}, 32'h1);
        bus_write(8'h0C, 32'h10);
        check("R8 irq after clear", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_ignored();
        logic [31:0] r;
        bus_write(8'h28, 32'h0000_0003);
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h30, 32'hFFFF_FFFF);
        check("R10 pad_out unchanged", pad_out, 32'hF0F0_00A0);
        check("R10 pad_oe unchanged", pad_oe, 32'h0000_FF00);
        bus_read(8'h28, r); check("R10 rise unchanged", r, 32'h3);
        bus_read(8'h2C, r); check("R10 fall unchanged", r, 32'h0);
        bus_read(8'h0C, r); check("R10 pend unchanged", r, 32'h0);
        bus_read(8'h14, r); check("R10 alias reads zero", r, 32'h0);
        bus_read(8'h1C, r); check("R10 oe alias reads zero", r, 32'h0);
        bus_read(8'h08, r); check("R10 unmapped reads zero", r, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_outputs();
        t_oe();
        t_input();
        t_no_enable();
        t_rise_fall();
        t_collision();
        t_disable_keeps();
        t_ignored();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule